// File: doc/BRIEF.md
# Parity-Protected Translation Table with Scrubbing

This block is a small, fully associative cache of address translations. Each entry keeps a tag, a translated address, a valid flag and one parity bit over tag and address. A lookup returns the translated address one cycle later, or a miss. A fill writes one entry by index. A host-driven range invalidation removes every entry whose tag matches a base value under a mask.

Integrity errors are handled without ever failing a request. An entry whose stored parity disagrees with its contents is never returned. Any path that finds such an entry drops it silently: a lookup that matches it, the background scrubber, a manually started scrub pass, or a range-invalidation pass. A miss on that entry leads the surrounding logic to fetch the translation again from the host. Every removal of a bad entry is counted in a small error log, and a one-cycle interrupt event tells software to read the log. A fault-injection input corrupts the parity of a chosen entry so the error path can be tested. Parity checking can be turned off with a parameter.

Top module: `tt_top`

## Requirements
- R1: After a synchronous active-low reset, every entry is invalid, `lu_done`, `err_irq`, `err_first_valid` and `walk_busy` are 0, and `err_count` is 0.
- R2: A lookup answers in the cycle after `lu_valid` with `lu_done`=1. `lu_hit`=1 when a valid entry with an equal tag and good parity exists. `lu_addr` is the address of the lowest-index such entry, and `lu_addr` is 0 on a miss.
- R3: A fill writes tag, address, valid and parity (the XOR of all tag and address bits) into entry `fill_idx`. A lookup in the same cycle as a fill sees the contents from before that fill.
- R4: A lookup that matches a valid entry with bad parity reports a miss, invalidates that entry at the same edge, and logs it. A later lookup with the same tag misses without logging again.
- R5: `inj_valid` arms injection for `inj_idx`. The next fill to that index stores inverted parity and consumes the arm, so later fills to that index store correct parity.
- R6: When `scrub_interval` is N>0 and no pass is running, the scrubber visits one entry on every Nth idle cycle (no `lu_valid`, no `fill_valid`), in rising index order with wrap-around. A visited valid entry with bad parity is invalidated and logged. N=0 stops background visits.
- R7: `scrub_start` with `walk_busy`=0 starts a pass: `walk_busy` rises after that edge, entries 0 to ENTRIES-1 are each visited on one idle cycle, bad entries are removed and logged, and `walk_busy` falls after the last visit.
- R8: `inv_valid` with `walk_busy`=0 starts a pass of the same shape. It invalidates every valid entry whose tag satisfies ((tag ^ `inv_base`) & `inv_mask`)==0, and it also removes and logs bad-parity entries. Non-matching good entries stay. If both requests arrive together, `inv_valid` wins. Both requests are ignored while `walk_busy`=1.
- R9: `err_count` rises by one, saturating at 2^CNT_W-1, at each edge where any bad entry is removed. `err_first_idx` takes the lowest removed index when `err_first_valid` is 0, then holds. `log_clear` empties the log, and an event in the same cycle is logged after the clear.
- R10: `err_irq` is a one-cycle pulse in the cycle after each edge where an error is logged.
- R11: With PARITY_EN=0 no entry is treated as bad, so an entry filled under injection still hits and nothing is logged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lu_valid | input | 1 | Lookup request |
| lu_tag | input | TAG_W | Lookup tag |
| lu_done | output | 1 | Lookup response valid |
| lu_hit | output | 1 | Lookup found a good entry |
| lu_addr | output | ADDR_W | Translated address, 0 on miss |
| fill_valid | input | 1 | Write an entry |
| fill_idx | input | IDX_W | Entry to write |
| fill_tag | input | TAG_W | Tag to write |
| fill_addr | input | ADDR_W | Address to write |
| inv_valid | input | 1 | Start range invalidation pass |
| inv_base | input | TAG_W | Tag base for invalidation |
| inv_mask | input | TAG_W | Tag bits compared |
| scrub_start | input | 1 | Start a manual scrub pass |
| scrub_interval | input | IVL_W | Idle cycles per background visit, 0 = off |
| inj_valid | input | 1 | Arm parity fault injection |
| inj_idx | input | IDX_W | Entry to corrupt on its next fill |
| log_clear | input | 1 | Empty the error log |
| walk_busy | output | 1 | A scrub or invalidation pass is running |
| err_count | output | CNT_W | Saturating count of removal events |
| err_first_idx | output | IDX_W | Index of the first logged bad entry |
| err_first_valid | output | 1 | err_first_idx holds a value |
| err_irq | output | 1 | One-cycle event: log updated |

## Verification
The bench goes after the boundaries of the error path. A lookup that returned a bad entry would report a hit with the stored address. An entry left valid after removal would be logged a second time on the next lookup. Injection that is not one-shot would keep corrupting refills. A scrubber that counted busy cycles, or started at the wrong index, would log its event a few cycles off the expected edge. An invalidation compare that ignored the mask would drop or keep the wrong neighbours. A log that did not saturate would wrap to a small count. A clear that took priority over a same-cycle event would lose that event. A random phase of mixed fills and lookups, with some of each in the same cycle, is compared against a model table to catch lowest-index and read-before-write mistakes.

// File: rtl/tt_pkg.sv
// Shared types for the translation table.
// Assumes nothing beyond being compiled before the modules that import it.
package tt_pkg;
    typedef enum logic [1:0] {
        WALK_IDLE  = 2'd0,
        WALK_SCRUB = 2'd1,
        WALK_INV   = 2'd2
    } walk_mode_e;
endpackage

// File: rtl/tt_array.sv
// Entry storage: valid, tag, address and one parity bit per entry.
// Computes a per-entry bad-parity flag and applies parity fault injection.
// Assumes at most one fill per cycle; a fill to an entry beats a kill to it.
module tt_array #(
    parameter int N         = 8,
    parameter int TAG_W     = 12,
    parameter int ADDR_W    = 16,
    parameter int IDX_W     = 3,
    parameter bit PARITY_EN = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fill_valid,
    input  logic [IDX_W-1:0]             fill_idx,
    input  logic [TAG_W-1:0]             fill_tag,
    input  logic [ADDR_W-1:0]            fill_addr,
    input  logic                         inj_valid,
    input  logic [IDX_W-1:0]             inj_idx,
    input  logic [N-1:0]                 kill,
    output logic [N-1:0]                 ent_valid,
    output logic [N-1:0][TAG_W-1:0]      ent_tag,
    output logic [N-1:0][ADDR_W-1:0]     ent_addr,
    output logic [N-1:0]                 ent_bad
);
    logic [N-1:0] par_q;
    logic         armed_q;
    logic [IDX_W-1:0] armed_idx_q;
    logic         flip;

    // Injection flips parity only on a fill that hits the armed index.
    assign flip = armed_q && fill_valid && (fill_idx == armed_idx_q);

    // Arm on request; consume on the targeted fill; a new request re-arms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q     <= 1'b0;
            armed_idx_q <= '0;
        end else begin
            if (flip)
                armed_q <= 1'b0;
            if (inj_valid) begin
                armed_q     <= 1'b1;
                armed_idx_q <= inj_idx;
            end
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_ent
        // Write on fill, else drop on kill.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_valid[i] <= 1'b0;
                ent_tag[i]   <= '0;
                ent_addr[i]  <= '0;
                par_q[i]     <= 1'b0;
            end else if (fill_valid && (fill_idx == IDX_W'(i))) begin
                ent_valid[i] <= 1'b1;
                ent_tag[i]   <= fill_tag;
                ent_addr[i]  <= fill_addr;
                par_q[i]     <= (^{fill_tag, fill_addr}) ^ flip;
            end else if (kill[i]) begin
                ent_valid[i] <= 1'b0;
            end
        end

        if (PARITY_EN) begin : g_chk
            // Recompute parity and compare with the stored bit.
            assign ent_bad[i] = par_q[i] ^ (^{ent_tag[i], ent_addr[i]});
        end else begin : g_nochk
            assign ent_bad[i] = 1'b0;
        end
    end
endmodule

// File: rtl/tt_walker.sv
// Table walker: runs full scrub or invalidation passes and paced background visits.
// Visits happen only on idle cycles; a starting request suppresses the visit that cycle.
// Assumes requests are already gated by the caller with "not busy".
module tt_walker
    import tt_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = 3,
    parameter int IVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle,
    input  logic             scrub_req,
    input  logic             inv_req,
    input  logic [IVL_W-1:0] interval,
    output logic             visit,
    output logic [IDX_W-1:0] visit_idx,
    output logic             inv_mode,
    output logic             busy
);
    walk_mode_e       mode_q;
    logic [IDX_W-1:0] ptr_q;
    logic [IVL_W-1:0] cnt_q;
    logic             starting;
    logic             bg_due;

    assign starting  = (mode_q == WALK_IDLE) && (scrub_req || inv_req);
    assign bg_due    = (interval != '0) && (({1'b0, cnt_q} + 1'b1) >= {1'b0, interval});
    assign visit     = idle && !starting && ((mode_q != WALK_IDLE) || bg_due);
    assign visit_idx = ptr_q;
    assign inv_mode  = (mode_q == WALK_INV);
    assign busy      = (mode_q != WALK_IDLE);

    // Pass state, walk pointer and background pacing counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= WALK_IDLE;
            ptr_q  <= '0;
            cnt_q  <= '0;
        end else if (starting) begin
            mode_q <= inv_req ? WALK_INV : WALK_SCRUB;
            ptr_q  <= '0;
            cnt_q  <= '0;
        end else if (visit) begin
            ptr_q <= (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
            cnt_q <= '0;
            if (mode_q != WALK_IDLE && ptr_q == IDX_W'(N - 1))
                mode_q <= WALK_IDLE;
        end else if (mode_q == WALK_IDLE && idle && interval != '0) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tt_errlog.sv
// Correctable-error log: saturating event count, first failing index, event pulse.
// Assumes err_vec marks the entries removed for bad parity at this edge.
module tt_errlog #(
    parameter int N     = 8,
    parameter int IDX_W = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     err_vec,
    input  logic             clear,
    output logic [CNT_W-1:0] count,
    output logic [IDX_W-1:0] first_idx,
    output logic             first_valid,
    output logic             irq
);
    logic             any_err;
    logic [IDX_W-1:0] low_idx;

    assign any_err = |err_vec;

    // Lowest flagged index.
    always_comb begin
        low_idx = '0;
        for (int i = N - 1; i >= 0; i--)
            if (err_vec[i]) low_idx = IDX_W'(i);
    end

    // Update the log; clear first, then apply a same-cycle event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count       <= '0;
            first_idx   <= '0;
            first_valid <= 1'b0;
            irq         <= 1'b0;
        end else begin
            irq <= any_err;
            if (clear) begin
                count       <= any_err ? CNT_W'(1) : '0;
                first_valid <= any_err;
                if (any_err) first_idx <= low_idx;
            end else if (any_err) begin
                if (count != '1) count <= count + 1'b1;
                if (!first_valid) begin
                    first_valid <= 1'b1;
                    first_idx   <= low_idx;
                end
            end
        end
    end
endmodule

// File: rtl/tt_top.sv
// Parity-protected translation table with lookup, fill, range invalidation,
// background and manual scrubbing, and a correctable-error log.
// Assumes one fill per cycle; lookups answer one cycle later.
module tt_top #(
    parameter int N         = 8,
    parameter int TAG_W     = 12,
    parameter int ADDR_W    = 16,
    parameter int IVL_W     = 8,
    parameter int CNT_W     = 4,
    parameter bit PARITY_EN = 1'b1,
    localparam int IDX_W    = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lu_valid,
    input  logic [TAG_W-1:0]  lu_tag,
    output logic              lu_done,
    output logic              lu_hit,
    output logic [ADDR_W-1:0] lu_addr,
    input  logic              fill_valid,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              inv_valid,
    input  logic [TAG_W-1:0]  inv_base,
    input  logic [TAG_W-1:0]  inv_mask,
    input  logic              scrub_start,
    input  logic [IVL_W-1:0]  scrub_interval,
    input  logic              inj_valid,
    input  logic [IDX_W-1:0]  inj_idx,
    input  logic              log_clear,
    output logic              walk_busy,
    output logic [CNT_W-1:0]  err_count,
    output logic [IDX_W-1:0]  err_first_idx,
    output logic              err_first_valid,
    output logic              err_irq
);
    logic [N-1:0]              ent_valid, ent_bad, kill, err_vec;
    logic [N-1:0][TAG_W-1:0]   ent_tag;
    logic [N-1:0][ADDR_W-1:0]  ent_addr;
    logic [N-1:0]              tag_eq, good_hit, lu_bad, vis_hit, vis_bad, vis_match;
    logic                      visit, inv_mode, idle, inv_acc;
    logic [IDX_W-1:0]          visit_idx;
    logic [TAG_W-1:0]          base_q, mask_q;
    logic [ADDR_W-1:0]         hit_addr;

    assign idle    = !lu_valid && !fill_valid;
    assign inv_acc = inv_valid && !walk_busy;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign tag_eq[i]    = ent_valid[i] && (ent_tag[i] == lu_tag);
        assign good_hit[i]  = tag_eq[i] && !ent_bad[i];
        assign lu_bad[i]    = lu_valid && tag_eq[i] && ent_bad[i];
        assign vis_hit[i]   = visit && (visit_idx == IDX_W'(i)) && ent_valid[i];
        assign vis_bad[i]   = vis_hit[i] && ent_bad[i];
        assign vis_match[i] = vis_hit[i] && inv_mode &&
                              (((ent_tag[i] ^ base_q) & mask_q) == '0);
    end

    assign kill    = lu_bad | vis_bad | vis_match;
    assign err_vec = lu_bad | vis_bad;

    // Address of the lowest-index good hit.
    always_comb begin
        hit_addr = '0;
        for (int i = N - 1; i >= 0; i--)
            if (good_hit[i]) hit_addr = ent_addr[i];
    end

    // Registered lookup response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lu_done <= 1'b0;
            lu_hit  <= 1'b0;
            lu_addr <= '0;
        end else begin
            lu_done <= lu_valid;
            lu_hit  <= lu_valid && (|good_hit);
            lu_addr <= lu_valid ? hit_addr : '0;
        end
    end

    // Hold the invalidation range for the duration of the pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
        end else if (inv_acc) begin
            base_q <= inv_base;
            mask_q <= inv_mask;
        end
    end

    tt_array #(
        .N(N), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .PARITY_EN(PARITY_EN)
    ) u_array (
        .clk(clk), .rst_n(rst_n),
        .fill_valid(fill_valid), .fill_idx(fill_idx),
        .fill_tag(fill_tag), .fill_addr(fill_addr),
        .inj_valid(inj_valid), .inj_idx(inj_idx), .kill(kill),
        .ent_valid(ent_valid), .ent_tag(ent_tag), .ent_addr(ent_addr), .ent_bad(ent_bad)
    );

    tt_walker #(.N(N), .IDX_W(IDX_W), .IVL_W(IVL_W)) u_walker (
        .clk(clk), .rst_n(rst_n), .idle(idle),
        .scrub_req(scrub_start && !walk_busy), .inv_req(inv_acc),
        .interval(scrub_interval), .visit(visit), .visit_idx(visit_idx),
        .inv_mode(inv_mode), .busy(walk_busy)
    );

    tt_errlog #(.N(N), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_log (
        .clk(clk), .rst_n(rst_n), .err_vec(err_vec), .clear(log_clear),
        .count(err_count), .first_idx(err_first_idx),
        .first_valid(err_first_valid), .irq(err_irq)
    );
endmodule

// File: rtl/tt_top_chk.sv
// Port-level checker for tt_top, attached by bind.
// Assumes synchronous active-low reset; all properties are disabled during reset.
module tt_top_chk #(
    parameter int CNT_W     = 4,
    parameter int IDX_W     = 3,
    parameter int ADDR_W    = 16,
    parameter bit PARITY_EN = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lu_valid,
    input logic              lu_done,
    input logic              lu_hit,
    input logic [ADDR_W-1:0] lu_addr,
    input logic              log_clear,
    input logic [CNT_W-1:0]  err_count,
    input logic [IDX_W-1:0]  err_first_idx,
    input logic              err_first_valid,
    input logic              err_irq
);
    AST_DONE_AFTER_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        lu_valid |=> lu_done); // R2
    AST_HIT_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        lu_hit |-> lu_done); // R2
    AST_MISS_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (lu_done && !lu_hit) |-> (lu_addr == '0)); // R2
    AST_COUNT_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !log_clear |=> (err_count >= $past(err_count))); // R9
    AST_FIRST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (err_first_valid && !log_clear) |=> (err_first_valid && $stable(err_first_idx))); // R9
    AST_IRQ_HAS_LOG: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> (err_first_valid && err_count != '0)); // R10
    AST_PARITY_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !PARITY_EN |-> !err_irq); // R11
endmodule

bind tt_top tt_top_chk #(
    .CNT_W(CNT_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .PARITY_EN(PARITY_EN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lu_valid(lu_valid), .lu_done(lu_done),
    .lu_hit(lu_hit), .lu_addr(lu_addr), .log_clear(log_clear),
    .err_count(err_count), .err_first_idx(err_first_idx),
    .err_first_valid(err_first_valid), .err_irq(err_irq)
);

// File: tb/tb_tt_top.sv
// Bench for tt_top: directed corner cases plus a seeded random fill/lookup phase
// checked against a model table. A second instance runs with parity checking off.
module tb_tt_top;
    localparam int N = 8, TW = 12, AW = 16, IW = 3, VW = 8, CW = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic lu_valid = 0, fill_valid = 0, inv_valid = 0, scrub_start = 0, inj_valid = 0, log_clear = 0;
    logic [TW-1:0] lu_tag = 0, fill_tag = 0, inv_base = 0, inv_mask = 0;
    logic [AW-1:0] fill_addr = 0;
    logic [IW-1:0] fill_idx = 0, inj_idx = 0;
    logic [VW-1:0] scrub_interval = 0;
    logic lu_done, lu_hit, walk_busy, err_first_valid, err_irq;
    logic [AW-1:0] lu_addr;
    logic [CW-1:0] err_count;
    logic [IW-1:0] err_first_idx;
    logic np_done, np_hit, np_busy, np_fv, np_irq;
    logic [AW-1:0] np_addr;
    logic [CW-1:0] np_count;
    logic [IW-1:0] np_fidx;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tt_top #(.N(N), .TAG_W(TW), .ADDR_W(AW), .IVL_W(VW), .CNT_W(CW), .PARITY_EN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .lu_valid(lu_valid), .lu_tag(lu_tag),
        .lu_done(lu_done), .lu_hit(lu_hit), .lu_addr(lu_addr),
        .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_addr(fill_addr),
        .inv_valid(inv_valid), .inv_base(inv_base), .inv_mask(inv_mask),
        .scrub_start(scrub_start), .scrub_interval(scrub_interval),
        .inj_valid(inj_valid), .inj_idx(inj_idx), .log_clear(log_clear),
        .walk_busy(walk_busy), .err_count(err_count), .err_first_idx(err_first_idx),
        .err_first_valid(err_first_valid), .err_irq(err_irq));

    tt_top #(.N(N), .TAG_W(TW), .ADDR_W(AW), .IVL_W(VW), .CNT_W(CW), .PARITY_EN(1'b0)) dut_np (
        .clk(clk), .rst_n(rst_n), .lu_valid(lu_valid), .lu_tag(lu_tag),
        .lu_done(np_done), .lu_hit(np_hit), .lu_addr(np_addr),
        .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_addr(fill_addr),
        .inv_valid(inv_valid), .inv_base(inv_base), .inv_mask(inv_mask),
        .scrub_start(scrub_start), .scrub_interval(scrub_interval),
        .inj_valid(inj_valid), .inj_idx(inj_idx), .log_clear(log_clear),
        .walk_busy(np_busy), .err_count(np_count), .err_first_idx(np_fidx),
        .err_first_valid(np_fv), .err_irq(np_irq));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        lu_valid = 0; fill_valid = 0; inv_valid = 0; scrub_start = 0; inj_valid = 0; log_clear = 0;
    endtask

    task automatic do_reset();
        quiet();
        scrub_interval = 0;
        rst_n = 0;
        step(); step();
        rst_n = 1;
    endtask

    task automatic fill(input int idx, input int tag, input int addr);
        fill_valid = 1; fill_idx = IW'(idx); fill_tag = TW'(tag); fill_addr = AW'(addr);
        step();
        fill_valid = 0;
    endtask

    task automatic inject(input int idx);
        inj_valid = 1; inj_idx = IW'(idx);
        step();
        inj_valid = 0;
    endtask

    task automatic lookup(input string req, input int tag, input int ehit, input int eaddr);
        lu_valid = 1; lu_tag = TW'(tag);
        step();
        lu_valid = 0;
        chk({req, " done"}, int'(lu_done), 1);
        chk({req, " hit"}, int'(lu_hit), ehit);
        chk({req, " addr"}, int'(lu_addr), eaddr);
    endtask

    // Model-based expected lookup result: lowest valid matching index.
    bit          m_v[N];
    logic [TW-1:0] m_tag[N];
    logic [AW-1:0] m_addr[N];
    function automatic int exp_addr(input logic [TW-1:0] t);
        for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == t) return int'(m_addr[i]);
        return 0;
    endfunction
    function automatic int exp_hit(input logic [TW-1:0] t);
        for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == t) return 1;
        return 0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd12345));
        do_reset();
        // R1: reset state
        chk("R1 lu_done", int'(lu_done), 0);
        chk("R1 count", int'(err_count), 0);
        chk("R1 first_valid", int'(err_first_valid), 0);
        chk("R1 irq", int'(err_irq), 0);
        chk("R1 busy", int'(walk_busy), 0);
        lookup("R1 empty", 0, 0, 0);

        // R6: background scrub, interval 3, bad entry at index 2 found on 9th idle edge
        inject(2);
        fill(2, 12'h123, 16'h4567);
        scrub_interval = 3;
        for (int k = 1; k <= 8; k++) step();
        chk("R6 before visit", int'(err_count), 0);
        step();
        chk("R6 count", int'(err_count), 1);
        chk("R6 first idx", int'(err_first_idx), 2);
        chk("R10 irq pulse", int'(err_irq), 1);
        scrub_interval = 0;
        step();
        chk("R10 irq falls", int'(err_irq), 0);
        lookup("R6 removed", 12'h123, 0, 0);
        chk("R6 no relog", int'(err_count), 1);

        // R2, R3: lowest index, same-cycle fill and lookup
        do_reset();
        fill(6, 12'h0AB, 16'h6666);
        fill(1, 12'h0AB, 16'h1111);
        lookup("R2 lowest", 12'h0AB, 1, 16'h1111);
        lu_valid = 1; lu_tag = 12'h077;
        fill_valid = 1; fill_idx = 3; fill_tag = 12'h077; fill_addr = 16'h3333;
        step(); quiet();
        chk("R3 old view hit", int'(lu_hit), 0);
        lookup("R3 after fill", 12'h077, 1, 16'h3333);

        // R4, R5, R11: injected lookup error, one-shot, parity-off instance
        inject(4);
        fill(4, 12'h2C4, 16'hBEEF);
        lu_valid = 1; lu_tag = 12'h2C4;
        step(); lu_valid = 0;
        chk("R4 bad miss", int'(lu_hit), 0);
        chk("R4 count", int'(err_count), 1);
        chk("R9 first idx", int'(err_first_idx), 4);
        chk("R10 irq", int'(err_irq), 1);
        chk("R11 np hit", int'(np_hit), 1);
        chk("R11 np addr", int'(np_addr), 16'hBEEF);
        chk("R11 np count", int'(np_count), 0);
        lookup("R4 gone", 12'h2C4, 0, 0);
        chk("R4 logged once", int'(err_count), 1);
        fill(4, 12'h2C4, 16'hBEEF);
        lookup("R5 one-shot", 12'h2C4, 1, 16'hBEEF);

        // R9: first index holds, clear alone, clear with event, saturation
        inject(6); fill(6, 12'h0AB, 16'h6666);
        lu_valid = 1; lu_tag = 12'h0AB; step(); lu_valid = 0;
        chk("R9 count two", int'(err_count), 2);
        chk("R9 first held", int'(err_first_idx), 4);
        log_clear = 1; step(); log_clear = 0;
        chk("R9 cleared", int'(err_count), 0);
        chk("R9 cleared fv", int'(err_first_valid), 0);
        inject(2); fill(2, 12'h222, 16'h0002);
        log_clear = 1; lu_valid = 1; lu_tag = 12'h222; step(); quiet();
        chk("R9 clear+event", int'(err_count), 1);
        chk("R9 clear+event idx", int'(err_first_idx), 2);
        for (int k = 0; k < 17; k++) begin
            inject(0); fill(0, 12'h500, 16'h0500);
            lu_valid = 1; lu_tag = 12'h500; step(); lu_valid = 0;
        end
        chk("R9 saturate", int'(err_count), 15);

        // R7: manual scrub pass, bad entry at index 5 found on 6th idle edge
        do_reset();
        inject(5); fill(5, 12'h055, 16'h5555);
        scrub_start = 1; step(); scrub_start = 0;
        chk("R7 busy", int'(walk_busy), 1);
        for (int k = 1; k <= 5; k++) step();
        chk("R7 before idx5", int'(err_count), 0);
        step();
        chk("R7 idx5 logged", int'(err_count), 1);
        step(); chk("R7 still busy", int'(walk_busy), 1);
        step(); chk("R7 pass ends", int'(walk_busy), 0);

        // R8: range invalidation with mask, bad neighbour removed, busy requests ignored
        do_reset();
        fill(0, 12'h0A0, 16'h0100);
        fill(1, 12'h0A5, 16'h0101);
        fill(2, 12'h1A0, 16'h0102);
        inject(3); fill(3, 12'h0B0, 16'h0103);
        inv_valid = 1; scrub_start = 1; inv_base = 12'h0A0; inv_mask = 12'hFF0;
        step(); quiet();
        chk("R8 busy", int'(walk_busy), 1);
        inv_valid = 1; inv_base = 12'h000; inv_mask = 12'h000;
        step(); quiet();
        for (int k = 2; k <= 8; k++) step();
        chk("R8 done", int'(walk_busy), 0);
        chk("R8 bad logged", int'(err_count), 1);
        chk("R8 bad idx", int'(err_first_idx), 3);
        lookup("R8 match0", 12'h0A0, 0, 0);
        lookup("R8 match1", 12'h0A5, 0, 0);
        lookup("R8 kept", 12'h1A0, 1, 16'h0102);
        lookup("R8 bad gone", 12'h0B0, 0, 0);

        // R2, R3: random fills and lookups against the model
        do_reset();
        for (int i = 0; i < N; i++) m_v[i] = 0;
        for (int it = 0; it < 400; it++) begin
            logic [TW-1:0] t;
            int eh, ea;
            bit do_l, do_f;
            int fi;
            logic [TW-1:0] ft;
            logic [AW-1:0] fa;
            t = TW'($urandom_range(0, 5));
            do_l = ($urandom_range(0, 1) == 1);
            do_f = ($urandom_range(0, 2) != 0);
            fi = $urandom_range(0, N - 1);
            ft = TW'($urandom_range(0, 5));
            fa = AW'($urandom);
            eh = exp_hit(t); ea = exp_addr(t);
            lu_valid = do_l; lu_tag = t;
            fill_valid = do_f; fill_idx = IW'(fi); fill_tag = ft; fill_addr = fa;
            step(); quiet();
            if (do_l) begin
                chk("R2 rand hit", int'(lu_hit), eh);
                chk("R3 rand addr", int'(lu_addr), ea);
            end
            if (do_f) begin
                m_v[fi] = 1; m_tag[fi] = ft; m_addr[fi] = fa;
            end
        end
        chk("R9 rand no errors", int'(err_count), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule